// File: doc/BRIEF.md
# Filtered Interrupt Aggregator

This block collects two active-low interrupt requests, one from each downstream channel, and merges them into a single active-low request toward the host. Each request first passes through a synchronizer into the system clock domain. It then passes through a glitch filter whose rejection window depends on the direction of the change: a falling (asserting) change must persist for `LOW_REJ_CYC` clock cycles and a rising (releasing) change for `HIGH_REJ_CYC` cycles before the filtered level follows it.

The combined output is modelled as the enable of an open-drain driver: 1 pulls the shared line low and 0 releases it. It is active while either filtered request is asserted, so it behaves as the logical AND of the two active-low lines. Detection never depends on which channel the surrounding switch currently connects; no selection input exists. A two-bit status vector shows each filtered request, 1 meaning an interrupt is present. The register read path places bit 0 at control-register bit 4 and bit 1 at bit 5.

Top module: `irq_filtered_combiner`

## Requirements
- R1: After a synchronous active-low reset, both filtered levels are inactive, so `irq_status_o` is 2'b00 and `irq_pull_o` is 0.
- R2: `irq_pull_o` is 1 exactly when at least one bit of `irq_status_o` is 1, i.e. the output is the AND of the two active-low requests.
- R3: A low pulse on a request input lasting fewer than `LOW_REJ_CYC` clock cycles leaves the status bit and the output unchanged. A low level held for exactly `LOW_REJ_CYC` cycles is accepted.
- R4: While a request is accepted as active, a high pulse shorter than `HIGH_REJ_CYC` cycles does not release it. A high level held for `HIGH_REJ_CYC` cycles releases it.
- R5: `irq_status_o[0]` reflects request 0 and `irq_status_o[1]` reflects request 1, each 1 when that request is asserted (input low). Each request is detected independently of the other.
- R6: An accepted assertion appears on the outputs exactly `SYNC_STAGES + LOW_REJ_CYC` rising clock edges after the input falls. An accepted release appears `SYNC_STAGES + HIGH_REJ_CYC` edges after the input rises. With the defaults at 50 MHz, these are within 4 µs and 2 µs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_n_i | input | NUM_REQ | Raw asynchronous interrupt requests, active low, one per channel |
| irq_pull_o | output | 1 | Open-drain enable for the combined request: 1 pulls the line low |
| irq_status_o | output | NUM_REQ | Filtered requests, 1 = interrupt present (bit 0 → register bit 4, bit 1 → register bit 5) |

## Verification
The bench applies low pulses one cycle shorter than the low window and exactly as long as it, to separate a correct threshold from an off-by-one filter. It applies high glitches of both lengths while a request is held, to show that the release window is distinct from the assertion window. It asserts each request alone, both together, and releases them one at a time, to tell a true AND from a single-channel or swapped mapping. Exact edge counts after the input changes confirm the synchronizer depth and the latency bounds.

// File: rtl/irq_agg_pkg.sv
// Package: shared level encoding and sizing helpers for the interrupt aggregator.
// Assumes: requests are active low on the wire.
package irq_agg_pkg;

    typedef enum logic {
        LVL_ACTIVE = 1'b0,
        LVL_IDLE   = 1'b1
    } irq_level_e;

    // Bits needed to hold a count up to max(a, b).
    function automatic int unsigned cnt_bits(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

endpackage

// File: rtl/irq_sync_chain.sv
// Module: multi-flop synchronizer bringing one asynchronous level into clk.
// Assumes: the input is a slow level; reset value is the idle (high) level.
module irq_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    // Shift the raw level through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_pulse_filter.sv
// Module: asymmetric glitch filter for one active-low request.
// The filtered level follows the synchronized level only after the new value
// has been seen for LOW_REJ cycles (going active) or HIGH_REJ cycles (going idle).
// Assumes: input already synchronized; both windows are at least 1.
module irq_pulse_filter
    import irq_agg_pkg::*;
#(
    parameter int unsigned LOW_REJ  = 50,
    parameter int unsigned HIGH_REJ = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    output irq_level_e level_o
);
    localparam int unsigned CW = cnt_bits(LOW_REJ, HIGH_REJ);
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_REJ - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_REJ - 1);

    irq_level_e    filt_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] last_cnt;
    logic          differs;

    // Pick the window that applies to the pending change direction.
    always_comb begin
        last_cnt = (filt_q == LVL_IDLE) ? LOW_LAST : HIGH_LAST;
        differs  = (level_i != logic'(filt_q));
    end

    // Count consecutive differing cycles; flip once the window is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= LVL_IDLE;
            run_q  <= '0;
        end else if (!differs) begin
            run_q <= '0;
        end else if (run_q == last_cnt) begin
            filt_q <= irq_level_e'(level_i);
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = filt_q;
endmodule

// File: rtl/irq_filtered_combiner.sv
// Module: top of the filtered interrupt aggregator.
// Synchronizes and filters each active-low request, exposes the filtered
// requests as active-high status and drives a combined open-drain enable.
// Assumes: no channel selection gates detection.
module irq_filtered_combiner
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_REQ      = 2,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned LOW_REJ_CYC  = 50,
    parameter int unsigned HIGH_REJ_CYC = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] irq_req_n_i,
    output logic               irq_pull_o,
    output logic [NUM_REQ-1:0] irq_status_o
);
    logic [NUM_REQ-1:0] synced;
    irq_level_e         filt [NUM_REQ];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        irq_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (irq_req_n_i[g]),
            .q_o   (synced[g])
        );
        irq_pulse_filter #(.LOW_REJ(LOW_REJ_CYC), .HIGH_REJ(HIGH_REJ_CYC)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (synced[g]),
            .level_o (filt[g])
        );
        // Status bit is 1 when this request is active.
        assign irq_status_o[g] = (filt[g] == LVL_ACTIVE);
    end

    // Pull the shared line whenever any filtered request is active.
    always_comb begin
        irq_pull_o = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (filt[i] == LVL_ACTIVE) irq_pull_o = 1'b1;
        end
    end
endmodule

// File: rtl/irq_filtered_combiner_chk.sv
// Module: assertion checker for irq_filtered_combiner, attached by bind.
// Assumes: same parameters as the instance it watches.
module irq_filtered_combiner_chk #(
    parameter int unsigned NUM_REQ      = 2,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned LOW_REJ_CYC  = 50,
    parameter int unsigned HIGH_REJ_CYC = 25
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] irq_req_n_i,
    input logic               irq_pull_o,
    input logic [NUM_REQ-1:0] irq_status_o
);
    localparam int unsigned ASSERT_MAX  = SYNC_STAGES + LOW_REJ_CYC;
    localparam int unsigned RELEASE_MAX = SYNC_STAGES + HIGH_REJ_CYC;

    logic rst_seen_q;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: one edge after reset, outputs are idle.
    always_ff @(posedge clk) begin
        if (rst_seen_q === 1'b1 && rst_n) begin
            p_reset_idle_r1: assert (irq_status_o == '0 && irq_pull_o == 1'b0)
                else $error("R1 outputs not idle after reset");
        end
    end

    // R2: combined output agrees with the status vector.
    p_and_combine_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o == (irq_status_o != '0));

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_lat
        logic [15:0] wait_act_q, wait_rel_q;

        // Count cycles a raw level has disagreed with the reported status.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_act_q <= '0;
                wait_rel_q <= '0;
            end else begin
                wait_act_q <= (!irq_req_n_i[g] && !irq_status_o[g] && wait_act_q != 16'hFFFF)
                              ? wait_act_q + 1'b1 : '0;
                wait_rel_q <= (irq_req_n_i[g] && irq_status_o[g] && wait_rel_q != 16'hFFFF)
                              ? wait_rel_q + 1'b1 : '0;
            end
        end

        // R6: a held assertion is reported within the bound.
        p_assert_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wait_act_q <= 16'(ASSERT_MAX));

        // R6: a held release is reported within the bound.
        p_release_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wait_rel_q <= 16'(RELEASE_MAX));
    end
endmodule

bind irq_filtered_combiner irq_filtered_combiner_chk #(
    .NUM_REQ      (NUM_REQ),
    .SYNC_STAGES  (SYNC_STAGES),
    .LOW_REJ_CYC  (LOW_REJ_CYC),
    .HIGH_REJ_CYC (HIGH_REJ_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_req_n_i  (irq_req_n_i),
    .irq_pull_o   (irq_pull_o),
    .irq_status_o (irq_status_o)
);

// File: tb/irq_filtered_combiner_test.sv
// Scoreboard bench: driver pushes expectations, monitor compares at negedge.
module irq_filtered_combiner_test;
    localparam int SYNC = 2;
    localparam int LOWC = 50;
    localparam int HIGHC = 25;

    typedef struct {
        logic [1:0] st;
        logic       pull;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_n = 2'b11;
    logic       pull;
    logic [1:0] st;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];
    event chk_ev;

    irq_filtered_combiner #(
        .NUM_REQ(2), .SYNC_STAGES(SYNC), .LOW_REJ_CYC(LOWC), .HIGH_REJ_CYC(HIGHC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .irq_req_n_i(req_n),
        .irq_pull_o(pull), .irq_status_o(st)
    );

    always #10 clk = ~clk;

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_now(input logic [1:0] s, input logic p, input string tag);
        exp_t e;
        e.st = s; e.pull = p; e.tag = tag;
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pops and compares each expectation when signalled.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (st !== e.st || pull !== e.pull) begin
                    n_fail++;
                    $display("FAIL %s: status=%b pull=%b expected status=%b pull=%b",
                             e.tag, st, pull, e.st, e.pull);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        expect_now(2'b00, 1'b0, "R1 reset idle");

        // R3: low pulse one cycle short of the window is rejected.
        req_n[0] = 1'b0; wait_neg(LOWC - 1); req_n[0] = 1'b1;
        wait_neg(LOWC + 10);
        expect_now(2'b00, 1'b0, "R3 short low rejected");

        // R3/R6: low held exactly the window, exact edge of acceptance.
        req_n[0] = 1'b0;
        wait_neg(SYNC + LOWC - 1);
        expect_now(2'b00, 1'b0, "R6 not yet asserted one edge early");
        wait_neg(1);
        expect_now(2'b01, 1'b1, "R3 R5 R6 request 0 accepted on time");

        // R4: high glitch one cycle short of the release window is rejected.
        req_n[0] = 1'b1; wait_neg(HIGHC - 1); req_n[0] = 1'b0;
        wait_neg(HIGHC + 10);
        expect_now(2'b01, 1'b1, "R4 short high glitch rejected");

        // R4/R6: release held, exact edge of release.
        req_n[0] = 1'b1;
        wait_neg(SYNC + HIGHC - 1);
        expect_now(2'b01, 1'b1, "R6 not yet released one edge early");
        wait_neg(1);
        expect_now(2'b00, 1'b0, "R4 R6 request 0 released on time");

        // R5: request 1 alone maps to status bit 1.
        req_n[1] = 1'b0;
        wait_neg(SYNC + LOWC + 2);
        expect_now(2'b10, 1'b1, "R5 R2 request 1 alone");

        // R2: both active.
        req_n[0] = 1'b0;
        wait_neg(SYNC + LOWC + 2);
        expect_now(2'b11, 1'b1, "R2 both requests");

        // R2: release request 1 only, output stays pulled.
        req_n[1] = 1'b1;
        wait_neg(SYNC + HIGHC + 2);
        expect_now(2'b01, 1'b1, "R2 one remaining request holds output");

        // R2: release all.
        req_n[0] = 1'b1;
        wait_neg(SYNC + HIGHC + 2);
        expect_now(2'b00, 1'b0, "R2 all released");

        // R3: short low on request 1 while request 0 idle.
        req_n[1] = 1'b0; wait_neg(LOWC / 2); req_n[1] = 1'b1;
        wait_neg(LOWC + 10);
        expect_now(2'b00, 1'b0, "R3 short low on request 1 rejected");

        // R1: reset while active returns to idle.
        req_n = 2'b00;
        wait_neg(SYNC + LOWC + 2);
        expect_now(2'b11, 1'b1, "R5 both active before reset");
        rst_n = 1'b0; wait_neg(2); rst_n = 1'b1;
        expect_now(2'b00, 1'b0, "R1 reset clears active state");

        req_n = 2'b11;
        wait_neg(SYNC + HIGHC + 2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule